// File: doc/BRIEF.md
# Confidence-Gated Stride Address Predictor

This block predicts the next effective address of each load with a small table indexed directly by the program counter. It is trained on strides and gated by a confidence counter. The front end reads it at decode. When the entry for that PC is confident and a prefetched value has already arrived, the block hands that value to dependent instructions. When the entry is confident but no value has arrived yet, the block returns the predicted address, so the address computation can be skipped.

Every committed load trains its entry. Training rewrites the last address, moves the confidence counter, and rewrites the stride only while the entry is not confident, so a single irregular access at a loop boundary does not destroy a learned stride. A training step whose result is confident emits a prefetch for the next predicted address, provided a memory port is free in that cycle. The returned data comes back on a fill stream and is kept only if it still matches the entry's prediction.

The decode lookup and the commit update are plain control ports. Neither has back-pressure. The prefetch request has no ready signal: the caller states whether a port is free, and a request that finds no free port is dropped and never retried. The fill input is a valid/ready stream. A beat is taken on a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` falls only in a cycle where a commit update targets the same entry, and the source holds the beat until it is taken.

Top module: `stride_pred`

## Requirements
- R1: After reset every entry has last address 0, stride 0, confidence 0 and no valid value, so no lookup reports a hit.
- R2: The entry index is PC bits [PC_LSB+IDX_W-1:PC_LSB] (bits 5:2 by default), with no tag. Two PCs that share those bits read and train the same entry.
- R3: On each update, actual stride = update address − stored last address. The 2-bit counter rises by one (saturating at 3) when the actual stride equals the stored stride and falls by one (saturating at 0) otherwise. An entry counts as confident when its counter is 2 or more.
- R4: Every update writes the last address. The stride is replaced by the actual stride only when the counter was below 2 before the update; otherwise the stored stride is kept.
- R5: With `dec_valid` high and the entry confident, `dec_val_hit` is raised with `dec_value` if the value is valid. If the value is not valid, `dec_addr_hit` is raised instead. `dec_pred_addr` is last + stride. Both hit flags are low when `dec_valid` is low. A lookup sees the table state from before any write in the same cycle.
- R6: An update clears the value-valid bit of its entry.
- R7: `pf_valid` is high in an update cycle exactly when the counter after the update is 2 or more and `pf_port_free` is high. It carries `pf_addr` = update address + stride after the update and `pf_idx` = the entry index. A request that finds no free port is not held.
- R8: `fill_ready` is low only when `upd_valid` is high and the update index equals `fill_idx`. An accepted fill sets the value and its valid bit only if `fill_addr` equals the entry's last + stride in that cycle.
- R9: An accepted fill whose address differs from the entry's prediction leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode lookup enable |
| dec_pc | input | PC_W | PC of the load at decode |
| dec_addr_hit | output | 1 | Confident entry, value not yet present: use predicted address |
| dec_val_hit | output | 1 | Confident entry with valid value |
| dec_pred_addr | output | ADDR_W | Predicted effective address |
| dec_value | output | DATA_W | Prefetched value |
| upd_valid | input | 1 | Commit training strobe |
| upd_pc | input | PC_W | PC of the committed load |
| upd_addr | input | ADDR_W | Actual effective address |
| pf_valid | output | 1 | Prefetch issued this cycle |
| pf_port_free | input | 1 | A memory port is free this cycle |
| pf_addr | output | ADDR_W | Address to prefetch |
| pf_idx | output | IDX_W | Entry that will receive the fill |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Fill beat accepted |
| fill_idx | input | IDX_W | Entry the fill belongs to |
| fill_addr | input | ADDR_W | Address the data was fetched from |
| fill_data | input | DATA_W | Fetched data |

## Verification
The bound assertions check the following on every cycle:
- a prefetch appears only alongside an update and a free port;
- a confident entry's prefetch keeps the stored stride;
- an update leaves its entry without a valid value;
- a fill is refused whenever it collides with an update to the same entry;
- no hit is reported without a lookup.

Only the bench's scenarios can show the rest:
- that confidence builds and decays as specified;
- that a stride survives one irregular step;
- that PCs which alias share an entry;
- that a mismatched fill changes nothing.

Those behaviours unfold across several updates, and the bench compares them on every clock with its behavioural model.

// File: rtl/stride_pred_pkg.sv
package stride_pred_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MAX = 2'd3;
  localparam conf_t CONF_THR = 2'd2;

  // Saturating confidence step: up on a stride match, down otherwise.
  function automatic conf_t conf_step(input conf_t c, input logic match);
    if (match) return (c == CONF_MAX) ? c : conf_t'(c + 2'd1);
    else       return (c == 2'd0)     ? c : conf_t'(c - 2'd1);
  endfunction

  function automatic logic is_conf(input conf_t c);
    return c >= CONF_THR;
  endfunction

endpackage

// File: rtl/stride_pred_table.sv
module stride_pred_table
  import stride_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  // decode read port
  input  logic [IDX_W-1:0]  dec_idx,
  output logic [ADDR_W-1:0] dec_last,
  output logic [ADDR_W-1:0] dec_stride,
  output conf_t             dec_ctr,
  output logic [DATA_W-1:0] dec_val,
  output logic              dec_vld,
  // training read/write port
  input  logic [IDX_W-1:0]  upd_idx,
  output logic [ADDR_W-1:0] upd_last,
  output logic [ADDR_W-1:0] upd_stride,
  output conf_t             upd_ctr,
  input  logic              wr_upd_en,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride,
  input  conf_t             wr_ctr,
  // fill read/write port
  input  logic [IDX_W-1:0]  fill_idx,
  output logic [ADDR_W-1:0] fill_last,
  output logic [ADDR_W-1:0] fill_stride,
  input  logic              wr_fill_en,
  input  logic [DATA_W-1:0] wr_val,
  // value-valid bits of all entries
  output logic [(1<<IDX_W)-1:0] vld_vec
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] last_q   [DEPTH];
  logic [ADDR_W-1:0] stride_q [DEPTH];
  conf_t             ctr_q    [DEPTH];
  logic [DATA_W-1:0] val_q    [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        ctr_q[i]    <= '0;
        val_q[i]    <= '0;
      end
      vld_q <= '0;
    end else begin
      if (wr_fill_en) begin
        val_q[fill_idx] <= wr_val;
        vld_q[fill_idx] <= 1'b1;
      end
      // training wins over a fill on the same entry
      if (wr_upd_en) begin
        last_q[upd_idx]   <= wr_last;
        stride_q[upd_idx] <= wr_stride;
        ctr_q[upd_idx]    <= wr_ctr;
        vld_q[upd_idx]    <= 1'b0;
      end
    end
  end

  assign dec_last    = last_q[dec_idx];
  assign dec_stride  = stride_q[dec_idx];
  assign dec_ctr     = ctr_q[dec_idx];
  assign dec_val     = val_q[dec_idx];
  assign dec_vld     = vld_q[dec_idx];

  assign upd_last    = last_q[upd_idx];
  assign upd_stride  = stride_q[upd_idx];
  assign upd_ctr     = ctr_q[upd_idx];

  assign fill_last   = last_q[fill_idx];
  assign fill_stride = stride_q[fill_idx];

  assign vld_vec     = vld_q;

endmodule

// File: rtl/stride_pred_train.sv
module stride_pred_train
  import stride_pred_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] old_last,
  input  logic [ADDR_W-1:0] old_stride,
  input  conf_t             old_ctr,
  input  logic              port_free,
  output logic [ADDR_W-1:0] new_last,
  output logic [ADDR_W-1:0] new_stride,
  output conf_t             new_ctr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  logic [ADDR_W-1:0] act_stride;
  logic              match;

  always_comb begin
    act_stride = upd_addr - old_last;
    match      = (act_stride == old_stride);
    new_ctr    = conf_step(old_ctr, match);
    // a confident entry keeps its stride through one irregular step
    new_stride = is_conf(old_ctr) ? old_stride : act_stride;
    new_last   = upd_addr;
    pf_valid   = upd_valid && is_conf(new_ctr) && port_free;
    pf_addr    = upd_addr + new_stride;
  end

endmodule

// File: rtl/stride_pred_fill.sv
module stride_pred_fill #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [ADDR_W-1:0] ent_last,
  input  logic [ADDR_W-1:0] ent_stride,
  output logic              fill_ready,
  output logic              wr_en
);

  logic addr_match;

  always_comb begin
    fill_ready = !(upd_valid && (upd_idx == fill_idx));
    addr_match = (fill_addr == ent_last + ent_stride);
    wr_en      = fill_valid && fill_ready && addr_match;
  end

endmodule

// File: rtl/stride_pred.sv
module stride_pred
  import stride_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [PC_W-1:0]   dec_pc,
  output logic              dec_addr_hit,
  output logic              dec_val_hit,
  output logic [ADDR_W-1:0] dec_pred_addr,
  output logic [DATA_W-1:0] dec_value,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [ADDR_W-1:0] upd_addr,
  output logic              pf_valid,
  input  logic              pf_port_free,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [IDX_W-1:0]  pf_idx,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int IDX_HI = PC_LSB + IDX_W - 1;

  logic [IDX_W-1:0]  dec_idx, upd_idx;
  logic              pc_bits_unused;

  logic [ADDR_W-1:0] dec_last, dec_stride;
  conf_t             dec_ctr;
  logic [DATA_W-1:0] dec_val;
  logic              dec_vld;

  logic [ADDR_W-1:0] upd_last_q, upd_stride_q;
  conf_t             upd_ctr_q;
  logic [ADDR_W-1:0] new_last, new_stride;
  conf_t             new_ctr;

  logic [ADDR_W-1:0] fill_last, fill_stride;
  logic              fill_wr;
  logic [DEPTH-1:0]  vld_vec;

  // direct, untagged indexing
  assign dec_idx = dec_pc[IDX_HI:PC_LSB];
  assign upd_idx = upd_pc[IDX_HI:PC_LSB];
  assign pc_bits_unused = ^{dec_pc[PC_W-1:IDX_HI+1], dec_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:IDX_HI+1], upd_pc[PC_LSB-1:0]};

  stride_pred_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_idx    (dec_idx),
    .dec_last   (dec_last),
    .dec_stride (dec_stride),
    .dec_ctr    (dec_ctr),
    .dec_val    (dec_val),
    .dec_vld    (dec_vld),
    .upd_idx    (upd_idx),
    .upd_last   (upd_last_q),
    .upd_stride (upd_stride_q),
    .upd_ctr    (upd_ctr_q),
    .wr_upd_en  (upd_valid),
    .wr_last    (new_last),
    .wr_stride  (new_stride),
    .wr_ctr     (new_ctr),
    .fill_idx   (fill_idx),
    .fill_last  (fill_last),
    .fill_stride(fill_stride),
    .wr_fill_en (fill_wr),
    .wr_val     (fill_data),
    .vld_vec    (vld_vec)
  );

  stride_pred_train #(.ADDR_W(ADDR_W)) u_train (
    .upd_valid  (upd_valid),
    .upd_addr   (upd_addr),
    .old_last   (upd_last_q),
    .old_stride (upd_stride_q),
    .old_ctr    (upd_ctr_q),
    .port_free  (pf_port_free),
    .new_last   (new_last),
    .new_stride (new_stride),
    .new_ctr    (new_ctr),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
  );

  stride_pred_fill #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fill (
    .fill_valid (fill_valid),
    .fill_idx   (fill_idx),
    .fill_addr  (fill_addr),
    .upd_valid  (upd_valid),
    .upd_idx    (upd_idx),
    .ent_last   (fill_last),
    .ent_stride (fill_stride),
    .fill_ready (fill_ready),
    .wr_en      (fill_wr)
  );

  assign pf_idx = upd_idx;

  // decode-time prediction
  logic dec_conf;
  always_comb begin
    dec_conf      = is_conf(dec_ctr);
    dec_pred_addr = dec_last + dec_stride;
    dec_value     = dec_val;
    dec_val_hit   = dec_valid && dec_conf && dec_vld;
    dec_addr_hit  = dec_valid && dec_conf && !dec_vld;
  end

endmodule

// File: rtl/stride_pred_chk.sv
module stride_pred_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dec_valid,
  input logic                 dec_addr_hit,
  input logic                 dec_val_hit,
  input logic                 upd_valid,
  input logic [ADDR_W-1:0]    upd_addr,
  input logic [IDX_W-1:0]     upd_idx,
  input logic [1:0]           old_ctr,
  input logic [ADDR_W-1:0]    old_stride,
  input logic                 pf_valid,
  input logic                 pf_port_free,
  input logic [ADDR_W-1:0]    pf_addr,
  input logic                 fill_valid,
  input logic                 fill_ready,
  input logic [IDX_W-1:0]     fill_idx,
  input logic [(1<<IDX_W)-1:0] vld_vec
);

  // R7
  pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (upd_valid && pf_port_free));

  // R4
  stride_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && old_ctr >= 2'd2) |-> (pf_addr == upd_addr + old_stride));

  // R6
  vld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !vld_vec[$past(upd_idx)]);

  // R8
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && upd_valid && fill_idx == upd_idx) |-> !fill_ready);

  // R5
  dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_addr_hit && !dec_val_hit));

endmodule

bind stride_pred stride_pred_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_addr_hit (dec_addr_hit),
  .dec_val_hit  (dec_val_hit),
  .upd_valid    (upd_valid),
  .upd_addr     (upd_addr),
  .upd_idx      (upd_idx),
  .old_ctr      (upd_ctr_q),
  .old_stride   (upd_stride_q),
  .pf_valid     (pf_valid),
  .pf_port_free (pf_port_free),
  .pf_addr      (pf_addr),
  .fill_valid   (fill_valid),
  .fill_ready   (fill_ready),
  .fill_idx     (fill_idx),
  .vld_vec      (vld_vec)
);

// File: tb/stride_pred_tb.sv
module stride_pred_tb;

  localparam int IDX_W = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 0;
  logic [31:0] dec_pc = 0;
  logic        dec_addr_hit, dec_val_hit;
  logic [31:0] dec_pred_addr, dec_value;
  logic        upd_valid = 0;
  logic [31:0] upd_pc = 0, upd_addr = 0;
  logic        pf_valid;
  logic        pf_port_free = 1;
  logic [31:0] pf_addr;
  logic [3:0]  pf_idx;
  logic        fill_valid = 0;
  logic        fill_ready;
  logic [3:0]  fill_idx = 0;
  logic [31:0] fill_addr = 0, fill_data = 0;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  logic [31:0] m_last [DEPTH];
  logic [31:0] m_str  [DEPTH];
  logic [31:0] m_val  [DEPTH];
  logic [1:0]  m_ctr  [DEPTH];
  logic        m_vld  [DEPTH];

  always #5 clk = ~clk;

  stride_pred u_dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_addr_hit(dec_addr_hit), .dec_val_hit(dec_val_hit),
    .dec_pred_addr(dec_pred_addr), .dec_value(dec_value),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_addr(upd_addr),
    .pf_valid(pf_valid), .pf_port_free(pf_port_free),
    .pf_addr(pf_addr), .pf_idx(pf_idx),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_idx(fill_idx),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  function automatic int pc_idx(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the model, then advance one clock
  task automatic step(input string tag);
    int di, ui, fi;
    logic conf, epf, efr, fwr;
    logic [31:0] act_s, nstr;
    logic [1:0] nctr;
    #1;
    di   = pc_idx(dec_pc);
    conf = m_ctr[di] >= 2;
    cmp(tag, "dec_addr_hit", dec_addr_hit, dec_valid && conf && !m_vld[di]);
    cmp(tag, "dec_val_hit", dec_val_hit, dec_valid && conf && m_vld[di]);
    if (dec_valid && conf) cmp(tag, "dec_pred_addr", dec_pred_addr, m_last[di] + m_str[di]);
    if (dec_valid && conf && m_vld[di]) cmp(tag, "dec_value", dec_value, m_val[di]);
    ui    = pc_idx(upd_pc);
    act_s = upd_addr - m_last[ui];
    if (act_s == m_str[ui]) nctr = (m_ctr[ui] == 2'd3) ? 2'd3 : m_ctr[ui] + 2'd1;
    else                    nctr = (m_ctr[ui] == 2'd0) ? 2'd0 : m_ctr[ui] - 2'd1;
    nstr = (m_ctr[ui] >= 2) ? m_str[ui] : act_s;
    epf  = upd_valid && (nctr >= 2) && pf_port_free;
    cmp(tag, "pf_valid", pf_valid, epf);
    if (epf) begin
      cmp(tag, "pf_addr", pf_addr, upd_addr + nstr);
      cmp(tag, "pf_idx", pf_idx, ui);
    end
    fi  = int'(fill_idx);
    efr = !(upd_valid && ui == fi);
    cmp(tag, "fill_ready", fill_ready, efr);
    fwr = fill_valid && efr && (fill_addr == m_last[fi] + m_str[fi]);
    @(posedge clk);
    if (fwr) begin m_val[fi] = fill_data; m_vld[fi] = 1'b1; end
    if (upd_valid) begin
      m_last[ui] = upd_addr; m_str[ui] = nstr; m_ctr[ui] = nctr; m_vld[ui] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    dec_valid = 0; upd_valid = 0; fill_valid = 0; pf_port_free = 1;
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] a, input string tag);
    idle(); upd_valid = 1; upd_pc = pc; upd_addr = a; step(tag);
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    idle(); dec_valid = 1; dec_pc = pc; step(tag);
  endtask

  task automatic fill(input int idx, input logic [31:0] a, input logic [31:0] d, input string tag);
    idle(); fill_valid = 1; fill_idx = idx[3:0]; fill_addr = a; fill_data = d; step(tag);
  endtask

  localparam logic [31:0] PC_A = 32'h0000_1010;  // index 4
  localparam logic [31:0] PC_B = 32'h0000_1050;  // aliases index 4

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_last[i] = 0; m_str[i] = 0; m_val[i] = 0; m_ctr[i] = 0; m_vld[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty table after reset
    for (int i = 0; i < DEPTH; i++) look(32'(i) << 2, "R1");
    // R3: confidence builds over a constant stride
    train(PC_A, 100, "R3"); train(PC_A, 108, "R3");
    train(PC_A, 116, "R3"); train(PC_A, 124, "R3");
    train(PC_A, 132, "R3");
    look(PC_A, "R3");
    // R4: one irregular step keeps the stride
    train(PC_A, 200, "R4");
    look(PC_A, "R4");
    train(PC_A, 208, "R4");
    // R8 / R5: matching fill then value supply
    fill(4, 216, 32'hCAFE_0001, "R8");
    look(PC_A, "R5");
    // R6: update clears value
    train(PC_A, 216, "R6");
    look(PC_A, "R6");
    // R9: mismatched fill ignored
    fill(4, 999, 32'hDEAD_BEEF, "R9");
    look(PC_A, "R9");
    // R2: aliasing PC sees the same entry
    look(PC_B, "R2");
    // R7: no free port drops the request
    idle(); upd_valid = 1; upd_pc = PC_A; upd_addr = 224; pf_port_free = 0; step("R7");
    idle(); step("R7");
    // R8: fill colliding with same-entry update is refused
    idle(); upd_valid = 1; upd_pc = PC_A; upd_addr = 232;
    fill_valid = 1; fill_idx = 4; fill_addr = 240; fill_data = 32'h1234; step("R8");
    look(PC_A, "R8");
    // mixed traffic
    for (int c = 0; c < 4000; c++) begin
      int p, f;
      p = int'($urandom_range(0, 5));
      idle();
      dec_valid = $urandom_range(0, 1) == 1;
      dec_pc = 32'(($urandom_range(0, 5) * 20) << 2);
      upd_valid = $urandom_range(0, 2) != 0;
      upd_pc = 32'((p * 20) << 2);
      upd_addr = ($urandom_range(0, 7) == 0) ? $urandom :
                 m_last[pc_idx(upd_pc)] + 32'(p * 4 + 4);
      pf_port_free = $urandom_range(0, 3) != 0;
      fill_valid = $urandom_range(0, 1) == 1;
      f = int'($urandom_range(0, 15));
      fill_idx = f[3:0];
      fill_addr = ($urandom_range(0, 1) == 1) ? m_last[f] + m_str[f] : $urandom;
      fill_data = $urandom;
      step("R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule